// File: doc/BRIEF.md
# Address-Transition Zero-Power Memory Controller

This block sits between a requester and a synchronous memory array. It keeps the array in a low-power standby state and powers it only briefly when a read is needed. It watches the read address and the select qualifiers. When the address changes, or when a read access begins, it enables the array for a fixed number of cycles equal to the array's read latency. It then captures the returned word into an output latch and drops the array back to standby. The requester sees the latched word, which stays valid while the array is idle.

The same controller can front a code memory or a scratch RAM. A standby-force input models a backup-supply condition. While it is held, the array stays off, the latch is frozen and address activity is ignored.

Top module: `atd_mem_ctrl`

## Requirements
- R1: After reset, `arr_en_o` is low and `rdata_o` is zero.
- R2: While a read access (`cs_i` and `rd_en_i` both high) holds the same address, no new window opens and `arr_en_o` stays low.
- R3: A new address during a read access raises `arr_en_o` in the following cycle, and it stays high for exactly `LAT` consecutive cycles.
- R4: After a window completes, `rdata_o` equals the array word for the address, and it stays unchanged while the array is in standby.
- R5: A rise of `cs_i` while `rd_en_i` is high starts a fetch even when the address is unchanged.
- R6: While `cs_i` or `rd_en_i` is low, address changes are ignored: `arr_en_o` stays low and `rdata_o` keeps its value.
- R7: An address change g cycles into an open window (1 <= g <= `LAT`) restarts the window. `arr_en_o` is then high for g+`LAT` cycles in total, and only the final address's word is latched.
- R8: While `stby_force_i` is high, `arr_en_o` is low from the next cycle on, any open window is abandoned, `rdata_o` is frozen and address changes are ignored. Once it is released, the first cycle with a read access starts a fetch, even for the same address.
- R9: During a window, `arr_addr_o` carries the address that opened or last restarted it, and stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | AW | Read address from the requester |
| cs_i | input | 1 | Chip select, active high |
| rd_en_i | input | 1 | Read enable, active high |
| stby_force_i | input | 1 | Forces standby and freezes the latch |
| arr_en_o | output | 1 | Array enable; low means standby |
| arr_addr_o | output | AW | Address presented to the array |
| arr_rdata_i | input | DW | Read data returned by the array |
| rdata_o | output | DW | Latched read data |

## Verification
The main function is swept over every address of a small configuration, stepping through consecutive distinct addresses. This shows whether each window has the right length and whether each latched word matches its own address rather than a neighbour's. Held addresses, toggled chip select and dropped read enable separate true transitions from mere activity on the select lines. Retriggers at every offset inside the window, and force applied both while idle and mid-window, distinguish restart, abandon and freeze behaviour.

// File: rtl/atd_pkg.sv
// Shared types for the address-transition memory controller.
package atd_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_LATCH   = 2'd2
    } atd_state_e;
endpackage

// File: rtl/atd_detect.sv
// Transition detector: flags a new read access or an address change while reading.
// Assumes inputs are synchronous to clk. Under forced standby it forgets the
// previous access, so that the first access after release always triggers.
module atd_detect #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          cs_i,
    input  logic          rd_en_i,
    input  logic          stby_force_i,
    output logic          trig_o
);
    logic          access;
    logic          prev_acc_q;
    logic [AW-1:0] prev_addr_q;

    // Current cycle is a read access.
    assign access = cs_i && rd_en_i;

    // Remember last address and whether the last cycle was an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_acc_q  <= 1'b0;
            prev_addr_q <= '0;
        end else if (stby_force_i) begin
            prev_acc_q  <= 1'b0;
        end else begin
            prev_acc_q  <= access;
            prev_addr_q <= addr_i;
        end
    end

    // Trigger on a fresh access or an address change during an access.
    always_comb begin
        trig_o = access && !stby_force_i &&
                 (!prev_acc_q || (addr_i != prev_addr_q));
    end

    // R6
    no_access_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_i && rd_en_i) |-> !trig_o);
endmodule

// File: rtl/atd_seq.sv
// Power sequencer: STANDBY -> ACTIVE (LAT cycles) -> LATCH -> STANDBY.
// Assumes the array delivers data LAT enabled cycles after a stable address.
// A trigger restarts the window; forced standby aborts it.
module atd_seq
    import atd_pkg::*;
#(
    parameter int AW  = 11,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic [AW-1:0] addr_i,
    input  logic          stby_force_i,
    output logic          arr_en_o,
    output logic [AW-1:0] arr_addr_o,
    output logic          cap_o
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(LAT - 1);

    atd_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] addr_q;

    // Next-state and window counter decision.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (stby_force_i) begin
            state_d = ST_STANDBY;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_STANDBY: if (trig_i) begin
                    state_d = ST_ACTIVE;
                    cnt_d   = '0;
                end
                ST_ACTIVE: begin
                    if (trig_i) begin
                        cnt_d = '0;
                    end else if (cnt_q == CNT_LAST) begin
                        state_d = ST_LATCH;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_LATCH: begin
                    if (trig_i) begin
                        state_d = ST_ACTIVE;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_STANDBY;
                    end
                end
                default: state_d = ST_STANDBY;
            endcase
        end
    end

    // State, counter and array address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
            cnt_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (trig_i) addr_q <= addr_i;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        arr_en_o   = (state_q == ST_ACTIVE);
        arr_addr_o = addr_q;
        cap_o      = (state_q == ST_LATCH) && !trig_i && !stby_force_i;
    end

    // R3
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !stby_force_i) |=> arr_en_o);
    // R8
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stby_force_i |=> (!arr_en_o && !cap_o));
    // R2
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && !trig_i) |=> !arr_en_o);
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_en_o && !trig_i) |=> $stable(arr_addr_o));
endmodule

// File: rtl/atd_latch.sv
// Output data latch: loads the array word on a capture strobe, holds otherwise.
// Assumes the array output is stable in the capture cycle.
module atd_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] dout_o
);
    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)     dout_o <= '0;
        else if (cap_i) dout_o <= din_i;
    end

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(dout_o));
endmodule

// File: rtl/atd_mem_ctrl.sv
// Top: zero-power read controller for a synchronous array with LAT read latency.
// Assumes all inputs are synchronous to clk.
module atd_mem_ctrl #(
    parameter int AW  = 11,
    parameter int DW  = 8,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          cs_i,
    input  logic          rd_en_i,
    input  logic          stby_force_i,
    output logic          arr_en_o,
    output logic [AW-1:0] arr_addr_o,
    input  logic [DW-1:0] arr_rdata_i,
    output logic [DW-1:0] rdata_o
);
    logic trig;
    logic cap;

    atd_detect #(.AW(AW)) u_detect (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cs_i(cs_i),
        .rd_en_i(rd_en_i), .stby_force_i(stby_force_i), .trig_o(trig)
    );

    atd_seq #(.AW(AW), .LAT(LAT)) u_seq (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .addr_i(addr_i),
        .stby_force_i(stby_force_i), .arr_en_o(arr_en_o),
        .arr_addr_o(arr_addr_o), .cap_o(cap)
    );

    atd_latch #(.DW(DW)) u_latch (
        .clk(clk), .rst_n(rst_n), .cap_i(cap), .din_i(arr_rdata_i),
        .dout_o(rdata_o)
    );

    // R8
    force_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stby_force_i |=> $stable(rdata_o));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!arr_en_o && rdata_o == '0));
endmodule

// File: tb/atd_mem_ctrl_tb.sv
`timescale 1ns/1ps
module atd_mem_ctrl_tb;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs = 1'b0, rd = 1'b0, force_sb = 1'b0;
    logic          arr_en;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_rdata;
    logic [DW-1:0] rdata;
    logic [DW-1:0] pipe [LAT];
    int            en_cnt = 0;
    int            total = 0, bad = 0;
    bit            done = 0;

    always #2.5 clk = ~clk;

    atd_mem_ctrl #(.AW(AW), .DW(DW), .LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .cs_i(cs), .rd_en_i(rd),
        .stby_force_i(force_sb), .arr_en_o(arr_en), .arr_addr_o(arr_addr),
        .arr_rdata_i(arr_rdata), .rdata_o(rdata)
    );

    function automatic logic [DW-1:0] word_of(input int a);
        return DW'((a * 37 + 5) & 8'hff);
    endfunction

    // Array model: LAT-stage read pipeline advancing only when enabled.
    always @(posedge clk) begin
        if (arr_en) begin
            pipe[0] <= word_of(int'(arr_addr));
            for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
        end
    end
    assign arr_rdata = pipe[LAT-1];

    // Count enabled cycles.
    always @(posedge clk) if (rst_n && arr_en) en_cnt <= en_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full read of one new address.
    task automatic do_read(input int a);
        int base;
        base = en_cnt;
        addr = AW'(a); cs = 1'b1; rd = 1'b1;
        step(1);
        chk(arr_en == 1'b1, "R3 start", int'(arr_en), 1);
        chk(int'(arr_addr) == a, "R9 addr", int'(arr_addr), a);
        step(LAT + 3);
        chk(en_cnt - base == LAT, "R3 window", en_cnt - base, LAT);
        chk(rdata == word_of(a), "R4 data", int'(rdata), int'(word_of(a)));
    endtask

    initial begin
        int base;
        logic [DW-1:0] keep;
        step(3);
        chk(arr_en == 1'b0, "R1 en", int'(arr_en), 0);
        chk(rdata == '0, "R1 data", int'(rdata), 0);
        rst_n = 1'b1;
        step(2);

        // Sweep every address.
        for (int a = 0; a < (1 << AW); a++) do_read(a);

        // R2: held address, no new window; data held.
        base = en_cnt;
        step(8);
        chk(en_cnt - base == 0, "R2 held", en_cnt - base, 0);
        chk(rdata == word_of((1 << AW) - 1), "R4 hold", int'(rdata),
            int'(word_of((1 << AW) - 1)));

        // R5: chip select toggle on same address.
        for (int a = 3; a < 6; a++) begin
            do_read(a);
            cs = 1'b0; step(2);
            base = en_cnt;
            cs = 1'b1; step(LAT + 4);
            chk(en_cnt - base == LAT, "R5 cs rise", en_cnt - base, LAT);
            chk(rdata == word_of(a), "R5 data", int'(rdata), int'(word_of(a)));
        end

        // R6: ignored address changes with cs or rd low.
        for (int m = 0; m < 2; m++) begin
            keep = rdata;
            base = en_cnt;
            if (m == 0) rd = 1'b0; else cs = 1'b0;
            for (int a = 8; a < 12; a++) begin addr = AW'(a); step(1); end
            step(3);
            chk(en_cnt - base == 0, "R6 no fetch", en_cnt - base, 0);
            chk(rdata == keep, "R6 data", int'(rdata), int'(keep));
            do_read(12 + m);
        end

        // R7: retrigger at every offset inside the window.
        for (int g = 1; g <= LAT; g++) begin
            for (int a = 0; a < (1 << AW); a += 5) begin
                int a2;
                a2 = (a + 7) % (1 << AW);
                base = en_cnt;
                addr = AW'(a); step(g);
                addr = AW'(a2); step(LAT + 4);
                chk(en_cnt - base == g + LAT, "R7 window", en_cnt - base, g + LAT);
                chk(rdata == word_of(a2), "R7 data", int'(rdata), int'(word_of(a2)));
            end
            do_read(14);
        end

        // R8: force while idle, then release on the same address.
        do_read(6);
        force_sb = 1'b1;
        base = en_cnt;
        for (int a = 0; a < 4; a++) begin addr = AW'(a + 9); step(1); end
        step(3);
        chk(en_cnt - base == 0, "R8 idle force", en_cnt - base, 0);
        chk(rdata == word_of(6), "R8 frozen", int'(rdata), int'(word_of(6)));
        base = en_cnt;
        force_sb = 1'b0; step(LAT + 4);
        chk(en_cnt - base == LAT, "R8 release", en_cnt - base, LAT);
        chk(rdata == word_of(12), "R8 release data", int'(rdata), int'(word_of(12)));

        // R8: force in the middle of a window.
        base = en_cnt;
        addr = AW'(2); step(1);
        force_sb = 1'b1; step(1);
        chk(arr_en == 1'b0, "R8 abort en", int'(arr_en), 0);
        step(4);
        chk(en_cnt - base == 1, "R8 abort count", en_cnt - base, 1);
        chk(rdata == word_of(12), "R8 abort data", int'(rdata), int'(word_of(12)));
        force_sb = 1'b0; step(LAT + 4);
        chk(rdata == word_of(2), "R8 refetch", int'(rdata), int'(word_of(2)));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule